// File: doc/BRIEF.md
# Interrupt and Control Input Conditioner

This block sits between a processor core and its raw control pins. It passes the maskable interrupt request, the non-maskable interrupt, the test pin and the reset pin through clock synchronizers. At every instruction boundary it decides whether the core must enter an interrupt acknowledge sequence, and which vector type to use. It also holds the core idle while a wait instruction finds the test pin high. It produces a clean internal reset, but only after the reset pin has been held long enough.

The core marks the last clock of each instruction with `instr_end`. In that cycle `take_int` tells the core to start acknowledge processing, and `int_type` gives the vector type. A latched rising edge on the non-maskable pin always wins and gives the fixed type `NMI_VEC`. Otherwise a level request, gated by the core's enable flag, gives the type on `ext_vector` from the external interrupt controller.

Top module: `ctl_input_cond`

## Requirements
- R1: A reset pin pulse of N consecutive clock samples drives `core_rst` high for exactly N-3 consecutive cycles when N is at least 4. It produces no `core_rst` at all when N is below 4 (RST_MIN = 4).
- R2: While `core_rst` is high, `take_int` and `wait_stall` are low. A pending non-maskable event is discarded.
- R3: `take_int` can be high only in a cycle with `instr_end` high. With the level request high and `int_en` high, it is high and `int_type` equals `ext_vector`.
- R4: When `int_en` is low, the level request produces no `take_int`.
- R5: A rising edge on `nmi_pin` stays pending across cycles without `instr_end`. It is taken at the next boundary whatever `int_en` is, with `int_type` = 2.
- R6: When a non-maskable event is pending and the level request is also active, `int_type` is 2, not `ext_vector`.
- R7: A pending non-maskable event clears in the cycle it is taken, so the following boundary sees only the level request.
- R8: `wait_stall` is high exactly when `wait_req` is high and the synchronized test pin is high. With the test pin low it stays low.
- R9: A change on the interrupt, test or reset pin reaches the decision logic after two clock edges, and not after one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_pin | input | 1 | Asynchronous reset pin, active high |
| intr_pin | input | 1 | Asynchronous maskable interrupt request, level, active high |
| nmi_pin | input | 1 | Asynchronous non-maskable interrupt, rising edge |
| test_pin | input | 1 | Asynchronous test pin examined by the wait instruction |
| int_en | input | 1 | Core interrupt-enable flag |
| instr_end | input | 1 | High in the last clock of each instruction |
| wait_req | input | 1 | High while the core executes a wait instruction |
| ext_vector | input | VEC_W | Vector type from the external interrupt controller |
| take_int | output | 1 | Enter interrupt acknowledge at this boundary |
| int_type | output | VEC_W | Vector type for the taken interrupt |
| wait_stall | output | 1 | Hold the core idle in the wait instruction |
| core_rst | output | 1 | Qualified internal reset |

## Verification
The boundary decision is swept over every combination of level request, enable flag, pending non-maskable event and boundary strobe. Each combination uses its own vector value, so a wrong priority shows up as a wrong type and not just as a missing take. The sweep checks the boundary after the take as well, which separates a pending event that clears from one that sticks. Reset pulses from one to eight cycles long show the exact four-cycle threshold and the length of the resulting internal reset. Test-pin and wait combinations, each sampled both one and two edges after the change, tell correct synchronizer depth apart from a shortened one.

// File: rtl/ctl_input_cond.sv
module ctl_input_cond #(
  parameter int VEC_W   = 8,
  parameter int NMI_VEC = 2,
  parameter int RST_MIN = 4,
  parameter int SYNC_N  = 2
) (
  input  logic             clk,
  input  logic             rst_pin,
  input  logic             intr_pin,
  input  logic             nmi_pin,
  input  logic             test_pin,
  input  logic             int_en,
  input  logic             instr_end,
  input  logic             wait_req,
  input  logic [VEC_W-1:0] ext_vector,
  output logic             take_int,
  output logic [VEC_W-1:0] int_type,
  output logic             wait_stall,
  output logic             core_rst
);
  localparam int CW = $clog2(RST_MIN + 1);
  localparam logic [CW-1:0] RCNT_TOP = CW'(RST_MIN - 1);

  logic [SYNC_N-1:0] rst_sr, intr_sr, nmi_sr, test_sr;
  logic rst_s, intr_s, nmi_s, test_s;
  logic nmi_d, nmi_edge, nmi_pend;
  logic [CW-1:0] rcnt;

  always_ff @(posedge clk) begin
    rst_sr  <= {rst_sr[SYNC_N-2:0],  rst_pin};
    intr_sr <= {intr_sr[SYNC_N-2:0], intr_pin};
    nmi_sr  <= {nmi_sr[SYNC_N-2:0],  nmi_pin};
    test_sr <= {test_sr[SYNC_N-2:0], test_pin};
  end

  assign rst_s  = rst_sr[SYNC_N-1];
  assign intr_s = intr_sr[SYNC_N-1];
  assign nmi_s  = nmi_sr[SYNC_N-1];
  assign test_s = test_sr[SYNC_N-1];

  always_ff @(posedge clk) begin
    if (!rst_s)               rcnt <= '0;
    else if (rcnt < RCNT_TOP) rcnt <= rcnt + 1'b1;
    core_rst <= rst_s && (rcnt == RCNT_TOP);
  end

  assign nmi_edge = nmi_s & ~nmi_d;

  always_ff @(posedge clk) begin
    nmi_d <= nmi_s;
    if (core_rst) nmi_pend <= 1'b0;
    else          nmi_pend <= (nmi_pend & ~instr_end) | nmi_edge;
  end

  assign take_int   = ~core_rst & instr_end & (nmi_pend | (intr_s & int_en));
  assign int_type   = nmi_pend ? VEC_W'(NMI_VEC) : ext_vector;
  assign wait_stall = ~core_rst & wait_req & test_s;
endmodule

module ctl_input_cond_chk #(
  parameter int VEC_W   = 8,
  parameter int NMI_VEC = 2
) (
  input logic             clk,
  input logic             core_rst,
  input logic             take_int,
  input logic [VEC_W-1:0] int_type,
  input logic             wait_stall,
  input logic             wait_req,
  input logic             instr_end,
  input logic             int_en,
  input logic             nmi_pend,
  input logic             nmi_edge
);
  always_comb begin
    if (core_rst) assert_quiet_in_reset_R2: assert (!take_int && !wait_stall);
  end

  assert_take_at_boundary_R3: assert property (@(posedge clk) disable iff (core_rst)
    take_int |-> instr_end);

  assert_mask_respected_R4: assert property (@(posedge clk) disable iff (core_rst)
    (take_int && !nmi_pend) |-> int_en);

  assert_nmi_type_wins_R6: assert property (@(posedge clk) disable iff (core_rst)
    (take_int && nmi_pend) |-> (int_type == VEC_W'(NMI_VEC)));

  assert_nmi_clears_R7: assert property (@(posedge clk) disable iff (core_rst)
    (instr_end && nmi_pend && !nmi_edge) |=> !nmi_pend);

  assert_stall_needs_wait_R8: assert property (@(posedge clk) disable iff (core_rst)
    wait_stall |-> wait_req);
endmodule

bind ctl_input_cond ctl_input_cond_chk #(.VEC_W(VEC_W), .NMI_VEC(NMI_VEC)) u_chk (
  .clk(clk), .core_rst(core_rst), .take_int(take_int), .int_type(int_type),
  .wait_stall(wait_stall), .wait_req(wait_req), .instr_end(instr_end),
  .int_en(int_en), .nmi_pend(nmi_pend), .nmi_edge(nmi_edge)
);

// File: tb/ctl_input_cond_bench.sv
module ctl_input_cond_bench;
  logic clk = 1'b0;
  logic rst_pin = 1'b0, intr_pin = 1'b0, nmi_pin = 1'b0, test_pin = 1'b0;
  logic int_en = 1'b0, instr_end = 1'b0, wait_req = 1'b0;
  logic [7:0] ext_vector = 8'h00;
  logic take_int, wait_stall, core_rst;
  logic [7:0] int_type;
  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  ctl_input_cond u_ctl_input_cond (
    .clk(clk), .rst_pin(rst_pin), .intr_pin(intr_pin), .nmi_pin(nmi_pin),
    .test_pin(test_pin), .int_en(int_en), .instr_end(instr_end),
    .wait_req(wait_req), .ext_vector(ext_vector), .take_int(take_int),
    .int_type(int_type), .wait_stall(wait_stall), .core_rst(core_rst)
  );

  task automatic tk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic do_reset(input int n);
    rst_pin = 1'b1; tk(n); rst_pin = 1'b0; tk(6);
  endtask

  task automatic summary;
    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  endtask

  initial begin
    #(8 * 200000);
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
    summary();
  end

  initial begin
    int cnt, idx;
    tk(2);
    do_reset(6);
    chk(core_rst == 1'b0, "R1 reset released", core_rst, 0);
    chk(take_int == 1'b0 && wait_stall == 1'b0, "R2 idle after reset", take_int, 0);

    // R1: pulse length sweep
    for (int n = 1; n <= 8; n++) begin
      cnt = 0;
      rst_pin = 1'b1;
      for (int c = 0; c < n + 10; c++) begin
        if (c == n) rst_pin = 1'b0;
        tk(1);
        if (core_rst) cnt++;
      end
      chk(cnt == ((n >= 4) ? n - 3 : 0), "R1 reset length", cnt, (n >= 4) ? n - 3 : 0);
    end

    // R2: outputs quiet during reset even with every request active
    intr_pin = 1'b1; int_en = 1'b1; test_pin = 1'b1; tk(3);
    instr_end = 1'b1; wait_req = 1'b1; rst_pin = 1'b1;
    for (int c = 0; c < 9; c++) begin
      if (c == 6) rst_pin = 1'b0;
      tk(1);
      if (core_rst) chk(!take_int && !wait_stall, "R2 quiet in reset", take_int, 0);
    end
    instr_end = 1'b0; wait_req = 1'b0; intr_pin = 1'b0; test_pin = 1'b0; int_en = 1'b0;
    tk(6);

    // R2: reset discards pending NMI
    nmi_pin = 1'b1; tk(1); nmi_pin = 1'b0; tk(4);
    do_reset(5);
    instr_end = 1'b1; #1;
    chk(take_int == 1'b0, "R2 pending cleared by reset", take_int, 0);
    tk(1); instr_end = 1'b0;

    // R3..R7: exhaustive boundary sweep
    idx = 0;
    for (int p = 0; p < 2; p++)
      for (int i = 0; i < 2; i++)
        for (int e = 0; e < 2; e++) begin
          bit exp_take;
          int exp_type;
          do_reset(5);
          intr_pin = 1'(i); int_en = 1'(e);
          ext_vector = 8'h40 + 8'(idx * 7);
          idx++;
          if (p == 1) begin nmi_pin = 1'b1; tk(1); nmi_pin = 1'b0; end
          tk(4);
          chk(take_int == 1'b0, "R3 no take without boundary", take_int, 0);
          tk(2);
          exp_take = (p == 1) || (i == 1 && e == 1);
          exp_type = (p == 1) ? 2 : int'(ext_vector);
          instr_end = 1'b1; #1;
          chk(take_int == exp_take, (p == 1) ? "R5 pending NMI taken" :
              ((e == 0) ? "R4 masked request" : "R3 level request"), take_int, exp_take);
          if (exp_take)
            chk(int_type == 8'(exp_type), (p == 1 && i == 1) ? "R6 NMI priority type" : "R3 vector type",
                int_type, exp_type);
          tk(1);
          chk(take_int == (i == 1 && e == 1), "R7 NMI cleared after take", take_int, (i == 1 && e == 1));
          if (i == 1 && e == 1)
            chk(int_type == ext_vector, "R7 level vector after NMI", int_type, ext_vector);
          instr_end = 1'b0;
        end

    // R7: held-high NMI does not retrigger
    intr_pin = 1'b0; nmi_pin = 1'b1; tk(5);
    instr_end = 1'b1; #1;
    chk(take_int == 1'b1, "R5 NMI edge taken", take_int, 1);
    tk(1);
    chk(take_int == 1'b0, "R7 held NMI no retrigger", take_int, 0);
    instr_end = 1'b0; nmi_pin = 1'b0; tk(3);

    // R8, R9: wait stall sweep with synchronizer depth
    for (int w = 0; w < 2; w++)
      for (int t = 0; t < 2; t++) begin
        test_pin = 1'b0; wait_req = 1'b0; tk(3);
        wait_req = 1'(w); test_pin = 1'(t);
        tk(1);
        chk(wait_stall == 1'b0, "R9 one edge not enough", wait_stall, 0);
        tk(1);
        chk(wait_stall == (w == 1 && t == 1), "R8 wait stall", wait_stall, (w == 1 && t == 1));
      end
    wait_req = 1'b0; test_pin = 1'b0; tk(3);

    // R9: interrupt pin latency
    int_en = 1'b1; instr_end = 1'b1; intr_pin = 1'b1;
    tk(1);
    chk(take_int == 1'b0, "R9 intr after one edge", take_int, 0);
    tk(1);
    chk(take_int == 1'b1, "R9 intr after two edges", take_int, 1);
    instr_end = 1'b0; intr_pin = 1'b0; tk(2);

    summary();
  end
endmodule